// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block is the sequencer of one DMA channel. Once enabled it copies 32-bit words from a source address to a destination address. Each word takes one read and then one write on a simple memory port. Both address pointers advance only inside the bits chosen by a per-pointer wrap mask, so a pointer can run through a circular buffer.

A transfer is cut into chunks. An acknowledge pulse marks the end of each chunk, and a hardware request input can pace the words. A stop input aborts the transfer with an error. An auto-restart setting replays the transfer from its starting point. In descriptor mode a separate fetch block supplies the address and size fields through a start/done handshake, and descriptors chain until one is flagged as the end of the list. A next-descriptor input can cut a paced descriptor transfer short.

Completion and abort raise status bits and, when enabled and unmasked, an interrupt. Arbitration among channels is left to the surrounding logic.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset `chEn`, `busy`, `done`, `err`, `intDone`, `intErr`, `irq`, `ackOut`, `descStart` and `memReq` are all low. While `chEn` is low no memory request is made. A one-cycle `startIn` pulse sets `chEn` on the next edge.
- R2: On the first active cycle the engine clears `done`, `err`, `intDone`, `intErr` and `srcA` and sets `busy`. Outside descriptor mode it latches the configuration inputs in that cycle.
- R3: Each word is one read (`memReq`=1, `memWe`=0, `memAddr`=source pointer) followed by one write (`memReq`=1, `memWe`=1, `memAddr`=destination pointer) of the data just read. Each phase is held until `memReady` is high. Exactly total-size words are written.
- R4: After each word a pointer `a` with wrap mask `m` becomes `(a & ~m) | (((a & m) + 4) & m)`. The mask is `cfgSrcMask` (`cfgDstMask`) when source (destination) increment is on, and zero otherwise, so that pointer then stays fixed.
- R5: The effective chunk equals the total size when `cfgChunk` is zero or larger than the total. `ackOut` is high for one cycle right after the write of each word whose running count is a multiple of the effective chunk, so a transfer gives floor(total/chunk) pulses.
- R6: With `hwMode` high, neither a transfer start nor a word read happens in a cycle where `hwReq` is low.
- R7: When `stopIn` is high while `chEn` is high, the next edge clears `chEn` and `busy` and sets `err`. If `ineErr` and `chMaskA` are high it also sets `intErr` and puts the channel's one-hot bit on `srcA`. Stop wins over a word that completes in the same cycle, so `done` stays low.
- R8: When the last word is written with no further descriptor and no auto-restart, `chEn` and `busy` clear and `done` sets. If `ineDone` and `chMaskA` are high, `intDone` sets and `srcA` gets bit `CH_IDX`. `irq` is `intDone | intErr`.
- R9: In descriptor mode `descStart` stays high until `descDone`. The descriptor's pointers, total size and increment flags are then used. At the end of a transfer whose descriptor had `descEol` low, the next descriptor is fetched and run without a done indication.
- R10: With `autoRestart` high, the end of a transfer reloads the latched start pointers and count and continues without setting `done`.
- R11: With `hwMode` and `descMode` both high, a high `ndIn` at the end of a descriptor fetch or at a word write ends the transfer without a done interrupt. The end follows the R9 and R10 chaining rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Enable pulse |
| stopIn | input | 1 | Abort request |
| hwMode | input | 1 | Pace words by hwReq |
| descMode | input | 1 | Take transfer fields from descriptors |
| autoRestart | input | 1 | Replay transfer at its end |
| incSrc | input | 1 | Source increment enable (register mode) |
| incDst | input | 1 | Destination increment enable (register mode) |
| ineDone | input | 1 | Done interrupt enable |
| ineErr | input | 1 | Error interrupt enable |
| chMaskA | input | 1 | This channel's bit of the global mask |
| cfgSrc | input | AW | Source start address |
| cfgDst | input | AW | Destination start address |
| cfgSrcMask | input | AW | Source wrap mask |
| cfgDstMask | input | AW | Destination wrap mask |
| cfgTotal | input | SZW | Total words (register mode) |
| cfgChunk | input | SZW | Chunk size in words |
| hwReq | input | 1 | Hardware request |
| ndIn | input | 1 | Next-descriptor request |
| ackOut | output | 1 | Chunk acknowledge pulse |
| descStart | output | 1 | Descriptor fetch request |
| descDone | input | 1 | Descriptor fields valid |
| descEol | input | 1 | Descriptor is end of list |
| descIncSrc | input | 1 | Descriptor source increment |
| descIncDst | input | 1 | Descriptor destination increment |
| descSrc | input | AW | Descriptor source address |
| descDst | input | AW | Descriptor destination address |
| descTotal | input | SZW | Descriptor total words |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Memory write (else read) |
| memAddr | output | AW | Memory address |
| memWdata | output | DW | Write data |
| memRdata | input | DW | Read data |
| memReady | input | 1 | Memory access completes this cycle |
| chEn | output | 1 | Channel enabled |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer completed |
| err | output | 1 | Transfer aborted |
| intDone | output | 1 | Done interrupt flag |
| intErr | output | 1 | Error interrupt flag |
| srcA | output | NUM_CH | One-hot interrupt source |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that can meet in one cycle are the abort and the completion of the final word. The bench raises `stopIn` in exactly the cycle the final write is on the port with `memReady` high. It then expects `err` and `intErr` set and `done` and `intDone` clear. A second collision, `ndIn` arriving together with a word write, is provoked after the first write of a paced descriptor transfer. It is judged by the exact number of writes and by the absence of a done interrupt.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_READ, ST_WRITE} engState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic loadCfg;   // latch configuration inputs
    logic loadDesc;  // latch descriptor fields
    logic restart;   // rewind pointers and counts
    logic capture;   // register read data
    logic advance;   // one word written
  } dpCtl_t;
endpackage

// File: rtl/dma_chan_dpath.sv
module dma_chan_dpath
  import dma_chan_pkg::*;
#(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int SZW = 12
) (
  input  logic           clk,
  input  logic           rstN,
  input  dpCtl_t         ctl,
  input  logic [AW-1:0]  cfgSrc,
  input  logic [AW-1:0]  cfgDst,
  input  logic [AW-1:0]  cfgSrcMask,
  input  logic [AW-1:0]  cfgDstMask,
  input  logic           cfgIncSrc,
  input  logic           cfgIncDst,
  input  logic [SZW-1:0] cfgTotal,
  input  logic [SZW-1:0] cfgChunk,
  input  logic [AW-1:0]  descSrc,
  input  logic [AW-1:0]  descDst,
  input  logic           descIncSrc,
  input  logic           descIncDst,
  input  logic [SZW-1:0] descTotal,
  input  logic [DW-1:0]  memRdata,
  output logic [AW-1:0]  srcAddr,
  output logic [AW-1:0]  dstAddr,
  output logic [DW-1:0]  wrData,
  output logic           lastWord,
  output logic           chunkEnd
);
  localparam logic [AW-1:0] STEP = AW'(DW / 8);

  logic [AW-1:0]  srcQ, dstQ, srcBase, dstBase, srcMask, dstMask;
  logic [SZW-1:0] totalQ, chunkQ, wordCnt, chunkCnt;
  logic [DW-1:0]  dataQ;

  logic [AW-1:0]  selSrc, selDst;
  logic           selIncSrc, selIncDst;
  logic [SZW-1:0] selTotal, effChunk;

  function automatic logic [AW-1:0] stepAddr(input logic [AW-1:0] a, input logic [AW-1:0] m);
    return (a & ~m) | (((a & m) + STEP) & m);
  endfunction

  always_comb begin
    selSrc    = ctl.loadDesc ? descSrc    : cfgSrc;
    selDst    = ctl.loadDesc ? descDst    : cfgDst;
    selIncSrc = ctl.loadDesc ? descIncSrc : cfgIncSrc;
    selIncDst = ctl.loadDesc ? descIncDst : cfgIncDst;
    selTotal  = ctl.loadDesc ? descTotal  : cfgTotal;
    effChunk  = (cfgChunk == '0 || cfgChunk > selTotal) ? selTotal : cfgChunk;
  end

  assign lastWord = ({1'b0, wordCnt} + (SZW+1)'(1)) >= {1'b0, totalQ};
  assign chunkEnd = ({1'b0, chunkCnt} + (SZW+1)'(1)) >= {1'b0, chunkQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ <= '0; dstQ <= '0; srcBase <= '0; dstBase <= '0;
      srcMask <= '0; dstMask <= '0;
      totalQ <= '0; chunkQ <= '0; wordCnt <= '0; chunkCnt <= '0;
    end else if (ctl.loadCfg || ctl.loadDesc) begin
      srcQ     <= selSrc;
      srcBase  <= selSrc;
      dstQ     <= selDst;
      dstBase  <= selDst;
      srcMask  <= selIncSrc ? cfgSrcMask : '0;
      dstMask  <= selIncDst ? cfgDstMask : '0;
      totalQ   <= selTotal;
      chunkQ   <= effChunk;
      wordCnt  <= '0;
      chunkCnt <= '0;
    end else if (ctl.restart) begin
      srcQ     <= srcBase;
      dstQ     <= dstBase;
      wordCnt  <= '0;
      chunkCnt <= '0;
    end else if (ctl.advance) begin
      srcQ     <= stepAddr(srcQ, srcMask);
      dstQ     <= stepAddr(dstQ, dstMask);
      wordCnt  <= wordCnt + 1'b1;
      chunkCnt <= chunkEnd ? '0 : chunkCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            dataQ <= '0;
    else if (ctl.capture) dataQ <= memRdata;
  end

  assign srcAddr = srcQ;
  assign dstAddr = dstQ;
  assign wrData  = dataQ;

  AST_SRC_WRAP_CONFINED: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !ctl.restart) |=> ((srcQ & ~srcMask) == ($past(srcQ) & ~srcMask))); // R4
  AST_DST_WRAP_CONFINED: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.advance && !ctl.restart) |=> ((dstQ & ~dstMask) == ($past(dstQ) & ~dstMask))); // R4
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (totalQ != '0) |-> (wordCnt <= totalQ)); // R3
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_IDX = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              stopIn,
  input  logic              hwMode,
  input  logic              descMode,
  input  logic              autoRestart,
  input  logic              ineDone,
  input  logic              ineErr,
  input  logic              maskBit,
  input  logic              hwReq,
  input  logic              ndIn,
  input  logic              descDone,
  input  logic              descEol,
  input  logic              memReady,
  input  logic              lastWord,
  input  logic              chunkEnd,
  output dpCtl_t            ctl,
  output logic              descStart,
  output logic              memReq,
  output logic              memWe,
  output logic              ackOut,
  output logic              chEn,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              intDone,
  output logic              intErr,
  output logic [NUM_CH-1:0] srcA,
  output logic              irq
);
  localparam logic [NUM_CH-1:0] CH_BIT = NUM_CH'(1) << CH_IDX;

  engState_t state;
  logic eolQ;
  logic stopHit, startXfer, fetchDone, wordDone, ndHit, endEol;
  logic termAny, termIrq, goFetch, goRestart, goFinish, paceOk;

  always_comb begin
    paceOk    = !hwMode || hwReq;
    stopHit   = chEn && stopIn;
    startXfer = (state == ST_IDLE) && chEn && !stopIn && paceOk;
    fetchDone = (state == ST_FETCH) && descDone && !stopHit;
    wordDone  = (state == ST_WRITE) && memReady && !stopHit;
    ndHit     = hwMode && descMode && ndIn;
    endEol    = fetchDone ? descEol : eolQ;
    termAny   = (fetchDone && ndHit) || (wordDone && (ndHit || lastWord));
    termIrq   = wordDone && !ndHit && lastWord;
    goFetch   = termAny && descMode && !endEol;
    goRestart = termAny && !goFetch && autoRestart;
    goFinish  = termAny && !goFetch && !autoRestart;

    ctl.loadCfg  = startXfer && !descMode;
    ctl.loadDesc = fetchDone;
    ctl.restart  = goRestart;
    ctl.capture  = memReq && !memWe && memReady;
    ctl.advance  = wordDone;

    memReq    = ((state == ST_READ) && paceOk) || (state == ST_WRITE);
    memWe     = (state == ST_WRITE);
    descStart = (state == ST_FETCH);
    irq       = intDone | intErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; eolQ <= 1'b1; ackOut <= 1'b0;
      chEn <= 1'b0; busy <= 1'b0; done <= 1'b0; err <= 1'b0;
      intDone <= 1'b0; intErr <= 1'b0; srcA <= '0;
    end else begin
      ackOut <= wordDone && chunkEnd;
      if (stopHit) begin
        chEn  <= 1'b0;
        busy  <= 1'b0;
        err   <= 1'b1;
        state <= ST_IDLE;
        if (ineErr && maskBit) begin
          intErr <= 1'b1;
          srcA   <= CH_BIT;
        end
      end else begin
        if (startIn && !chEn) chEn <= 1'b1;
        if (startXfer) begin
          done <= 1'b0; err <= 1'b0;
          intDone <= 1'b0; intErr <= 1'b0; srcA <= '0;
          busy  <= 1'b1;
          state <= descMode ? ST_FETCH : ST_READ;
        end
        if (ctl.capture) state <= ST_WRITE;
        if (fetchDone) eolQ <= descEol;
        if (fetchDone || wordDone) begin
          if (goFetch)       state <= ST_FETCH;
          else if (goFinish) state <= ST_IDLE;
          else               state <= ST_READ;
        end
        if (goFinish) begin
          chEn <= 1'b0;
          busy <= 1'b0;
          done <= 1'b1;
          if (termIrq && ineDone && maskBit) begin
            intDone <= 1'b1;
            srcA    <= CH_BIT;
          end
        end
      end
    end
  end

  AST_NO_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq); // R1
  AST_ACK_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> $past(memReq && memWe && memReady)); // R5
  AST_PACE_HOLDS_START: assert property (@(posedge clk) disable iff (!rstN)
    (hwMode && !hwReq && !busy && !stopIn) |=> !busy); // R6
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (chEn && stopIn && busy) |=> (err && !chEn && !busy && !done)); // R7
  AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcA)); // R8
  AST_FETCH_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (descStart && !descDone && !stopIn) |=> descStart); // R9
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int SZW    = 12,
  parameter int NUM_CH = 4,
  parameter int CH_IDX = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startIn,
  input  logic              stopIn,
  input  logic              hwMode,
  input  logic              descMode,
  input  logic              autoRestart,
  input  logic              incSrc,
  input  logic              incDst,
  input  logic              ineDone,
  input  logic              ineErr,
  input  logic              chMaskA,
  input  logic [AW-1:0]     cfgSrc,
  input  logic [AW-1:0]     cfgDst,
  input  logic [AW-1:0]     cfgSrcMask,
  input  logic [AW-1:0]     cfgDstMask,
  input  logic [SZW-1:0]    cfgTotal,
  input  logic [SZW-1:0]    cfgChunk,
  input  logic              hwReq,
  input  logic              ndIn,
  output logic              ackOut,
  output logic              descStart,
  input  logic              descDone,
  input  logic              descEol,
  input  logic              descIncSrc,
  input  logic              descIncDst,
  input  logic [AW-1:0]     descSrc,
  input  logic [AW-1:0]     descDst,
  input  logic [SZW-1:0]    descTotal,
  output logic              memReq,
  output logic              memWe,
  output logic [AW-1:0]     memAddr,
  output logic [DW-1:0]     memWdata,
  input  logic [DW-1:0]     memRdata,
  input  logic              memReady,
  output logic              chEn,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              intDone,
  output logic              intErr,
  output logic [NUM_CH-1:0] srcA,
  output logic              irq
);
  dpCtl_t        ctl;
  logic [AW-1:0] srcAddr, dstAddr;
  logic          lastWord, chunkEnd;

  dma_chan_ctrl #(.NUM_CH(NUM_CH), .CH_IDX(CH_IDX)) uCtrl (
    .clk, .rstN, .startIn, .stopIn, .hwMode, .descMode, .autoRestart,
    .ineDone, .ineErr, .maskBit(chMaskA), .hwReq, .ndIn, .descDone, .descEol,
    .memReady, .lastWord, .chunkEnd, .ctl, .descStart, .memReq, .memWe,
    .ackOut, .chEn, .busy, .done, .err, .intDone, .intErr, .srcA, .irq
  );

  dma_chan_dpath #(.AW(AW), .DW(DW), .SZW(SZW)) uDpath (
    .clk, .rstN, .ctl, .cfgSrc, .cfgDst, .cfgSrcMask, .cfgDstMask,
    .cfgIncSrc(incSrc), .cfgIncDst(incDst), .cfgTotal, .cfgChunk,
    .descSrc, .descDst, .descIncSrc, .descIncDst, .descTotal, .memRdata,
    .srcAddr, .dstAddr, .wrData(memWdata), .lastWord, .chunkEnd
  );

  assign memAddr = memWe ? dstAddr : srcAddr;
endmodule

// File: tb/tb_dma_chan_engine.sv
`timescale 1ns/1ps
module tb_dma_chan_engine;
  localparam int AW = 32, DW = 32, SZW = 12, NUM_CH = 4, CH_IDX = 2;
  localparam logic [NUM_CH-1:0] MYBIT = 4'b0100;

  logic clk = 1'b0, rstN = 1'b0;
  logic startIn = 0, stopIn = 0, hwMode = 0, descMode = 0, autoRestart = 0;
  logic incSrc = 0, incDst = 0, ineDone = 0, ineErr = 0, chMaskA = 0;
  logic [AW-1:0] cfgSrc = 0, cfgDst = 0, cfgSrcMask = 0, cfgDstMask = 0;
  logic [SZW-1:0] cfgTotal = 0, cfgChunk = 0;
  logic hwReq = 0, ndIn = 0, ackOut, descStart;
  logic descDone = 0, descEol = 0, descIncSrc = 0, descIncDst = 0;
  logic [AW-1:0] descSrc = 0, descDst = 0;
  logic [SZW-1:0] descTotal = 0;
  logic memReq, memWe, memReady;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, memRdata;
  logic chEn, busy, done, err, intDone, intErr, irq;
  logic [NUM_CH-1:0] srcA;

  dma_chan_engine #(.AW(AW), .DW(DW), .SZW(SZW), .NUM_CH(NUM_CH), .CH_IDX(CH_IDX)) dut (
    .clk, .rstN, .startIn, .stopIn, .hwMode, .descMode, .autoRestart, .incSrc, .incDst,
    .ineDone, .ineErr, .chMaskA, .cfgSrc, .cfgDst, .cfgSrcMask, .cfgDstMask, .cfgTotal,
    .cfgChunk, .hwReq, .ndIn, .ackOut, .descStart, .descDone, .descEol, .descIncSrc,
    .descIncDst, .descSrc, .descDst, .descTotal, .memReq, .memWe, .memAddr, .memWdata,
    .memRdata, .memReady, .chEn, .busy, .done, .err, .intDone, .intErr, .srcA, .irq
  );

  always #2.5 clk = ~clk;

  // Memory and descriptor-fetch models
  logic stallOn = 0;
  int cyc = 0, ackCnt = 0, wrCnt = 0, reqCnt = 0, hwViol = 0, descIdx = 0, descDly = 0;
  logic [AW-1:0] logAddr [64];
  logic [DW-1:0] logData [64];
  logic [AW-1:0] tSrc [16], tDst [16];
  logic [SZW-1:0] tTot [16];
  logic tEol [16];

  assign memRdata = 32'hC0DE_0000 ^ memAddr;
  assign memReady = !(stallOn && (cyc % 3 == 1));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (ackOut) ackCnt <= ackCnt + 1;
    if (memReq) reqCnt <= reqCnt + 1;
    if (memReq && !memWe && hwMode && !hwReq) hwViol <= hwViol + 1;
    if (memReq && memWe && memReady) begin
      logAddr[wrCnt % 64] <= memAddr;
      logData[wrCnt % 64] <= memWdata;
      wrCnt <= wrCnt + 1;
    end
    descDone <= 1'b0;
    if (descStart && !descDone) begin
      if (descDly == 2) begin
        descDone   <= 1'b1;
        descDly    <= 0;
        descSrc    <= tSrc[descIdx % 16];
        descDst    <= tDst[descIdx % 16];
        descTotal  <= tTot[descIdx % 16];
        descEol    <= tEol[descIdx % 16];
        descIncSrc <= 1'b1;
        descIncDst <= 1'b1;
        descIdx    <= descIdx + 1;
      end else descDly <= descDly + 1;
    end else if (!descStart) descDly <= 0;
  end

  int nChk = 0, nErr = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearCfg();
    @(negedge clk);
    hwMode = 0; descMode = 0; autoRestart = 0; incSrc = 1; incDst = 1;
    ineDone = 0; ineErr = 0; chMaskA = 0; hwReq = 0; ndIn = 0; stopIn = 0;
    cfgSrcMask = 32'hFFFF_FFFC; cfgDstMask = 32'hFFFF_FFFC;
    cfgChunk = 0; stallOn = 0;
  endtask

  task automatic pulseStart();
    @(negedge clk) startIn = 1;
    @(negedge clk) startIn = 0;
  endtask

  task automatic waitIdle(input int limit);
    for (int i = 0; i < limit; i++) begin
      if (!chEn) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic checkWrites(input int base, input int n, input logic [AW-1:0] dst,
                             input logic [AW-1:0] srcLo, input int srcMod, input int srcOff,
                             input bit dstFixed, input string req);
    for (int k = 0; k < n; k++) begin
      logic [AW-1:0] ea, es;
      ea = dstFixed ? dst : dst + AW'(4 * k);
      es = srcLo + AW'((srcOff + 4 * k) % srcMod);
      chk(logAddr[(base + k) % 64] == ea, req, logAddr[(base + k) % 64], ea);
      chk(logData[(base + k) % 64] == (32'hC0DE_0000 ^ es), req, logData[(base + k) % 64], 32'hC0DE_0000 ^ es);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    nChk++; nErr++;
    $display("FAIL watchdog: actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    int w0, a0, r0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk({chEn, busy, done, err, intDone, intErr, irq, ackOut, descStart, memReq} == '0,
        "R1 reset", {chEn, busy, done, err, intDone, intErr, irq, ackOut, descStart, memReq}, 0);
    r0 = reqCnt;
    repeat (10) @(negedge clk);
    chk(reqCnt == r0 && !chEn, "R1 idle without start", reqCnt - r0, 0);

    // Sweep total 1..6 x chunk 0..7: R3 R4 R5 R8
    for (int t = 1; t <= 6; t++) begin
      for (int c = 0; c <= 7; c++) begin
        int effC, expAck;
        clearCfg();
        cfgSrc = 32'h40; cfgDst = 32'h800; cfgTotal = SZW'(t); cfgChunk = SZW'(c);
        ineDone = 1; chMaskA = c[0]; stallOn = t[0];
        w0 = wrCnt; a0 = ackCnt;
        pulseStart();
        waitIdle(200);
        effC = (c == 0 || c > t) ? t : c;
        expAck = t / effC;
        chk(wrCnt - w0 == t, "R3 word count", wrCnt - w0, t);
        checkWrites(w0, t, 32'h800, 32'h40, 1 << 20, 0, 0, "R3 R4 copy");
        chk(ackCnt - a0 == expAck, "R5 chunk acks", ackCnt - a0, expAck);
        chk(done && !busy && !chEn && !err, "R8 finish status", {done, busy, chEn, err}, 4'b1000);
        chk(intDone == chMaskA && irq == chMaskA && srcA == (chMaskA ? MYBIT : 4'b0),
            "R8 done interrupt gating", {intDone, irq, srcA}, {chMaskA, chMaskA, chMaskA ? MYBIT : 4'b0});
      end
    end

    // Wrap mask on source, base 0x10: R2 then R4
    clearCfg();
    cfgSrc = 32'h10; cfgSrcMask = 32'h0C; cfgDst = 32'h900; cfgTotal = 6;
    w0 = wrCnt;
    pulseStart();
    @(negedge clk);
    chk(busy && !done && !intDone && srcA == 0, "R2 first active cycle", {busy, done, intDone}, 3'b100);
    waitIdle(200);
    chk(wrCnt - w0 == 6, "R4 wrap count", wrCnt - w0, 6);
    checkWrites(w0, 6, 32'h900, 32'h10, 16, 0, 0, "R4 wrap from 0x10");

    // Wrap mask, base 0x18
    clearCfg();
    cfgSrc = 32'h18; cfgSrcMask = 32'h0C; cfgDst = 32'h900; cfgTotal = 6; stallOn = 1;
    w0 = wrCnt;
    pulseStart();
    waitIdle(200);
    checkWrites(w0, 6, 32'h900, 32'h10, 16, 8, 0, "R4 wrap from 0x18");

    // Destination increment off
    clearCfg();
    incDst = 0; cfgSrc = 32'h40; cfgDst = 32'hA80; cfgTotal = 3;
    w0 = wrCnt;
    pulseStart();
    waitIdle(200);
    checkWrites(w0, 3, 32'hA80, 32'h40, 1 << 20, 0, 1, "R4 fixed destination");

    // Hardware pacing: R6
    clearCfg();
    hwMode = 1; cfgSrc = 32'h40; cfgDst = 32'h980; cfgTotal = 3;
    r0 = reqCnt; w0 = wrCnt;
    pulseStart();
    repeat (20) @(negedge clk);
    chk(reqCnt == r0 && !busy, "R6 no start while request low", reqCnt - r0, 0);
    for (int i = 0; i < 200; i++) begin
      hwReq = (i % 3 != 2);
      @(negedge clk);
      if (!chEn) break;
    end
    waitIdle(50);
    chk(wrCnt - w0 == 3 && done, "R6 paced completion", wrCnt - w0, 3);
    chk(hwViol == 0, "R6 no read while request low", hwViol, 0);

    // Stop colliding with final write: R7
    clearCfg();
    cfgSrc = 32'h40; cfgDst = 32'hC80; cfgTotal = 1; ineErr = 1; ineDone = 1; chMaskA = 1;
    pulseStart();
    for (int i = 0; i < 50; i++) begin
      if (memWe) break;
      @(negedge clk);
    end
    chk(memWe && memReady, "R7 setup final write", {memWe, memReady}, 2'b11);
    stopIn = 1;
    @(negedge clk) stopIn = 0;
    chk(err && !done && !chEn && !busy, "R7 stop wins", {err, done, chEn, busy}, 4'b1000);
    chk(intErr && !intDone && irq && srcA == MYBIT, "R7 error interrupt", {intErr, intDone, irq, srcA}, {3'b101, MYBIT});
    w0 = wrCnt;
    repeat (10) @(negedge clk);
    chk(wrCnt == w0, "R7 no writes after stop", wrCnt - w0, 0);

    // Stop with error interrupt disabled
    clearCfg();
    cfgSrc = 32'h40; cfgDst = 32'hC80; cfgTotal = 8; chMaskA = 1;
    pulseStart();
    repeat (4) @(negedge clk);
    stopIn = 1;
    @(negedge clk) stopIn = 0;
    chk(err && !intErr && !irq && srcA == 0, "R7 error interrupt gated", {err, intErr, irq}, 3'b100);

    // Descriptor chain: R9
    clearCfg();
    tSrc[descIdx % 16] = 32'h40; tDst[descIdx % 16] = 32'hA00; tTot[descIdx % 16] = 2; tEol[descIdx % 16] = 0;
    tSrc[(descIdx + 1) % 16] = 32'h80; tDst[(descIdx + 1) % 16] = 32'hB00; tTot[(descIdx + 1) % 16] = 3; tEol[(descIdx + 1) % 16] = 1;
    descMode = 1; incSrc = 0; incDst = 0; ineDone = 1; chMaskA = 1;
    w0 = wrCnt;
    pulseStart();
    waitIdle(300);
    chk(wrCnt - w0 == 5, "R9 chained word count", wrCnt - w0, 5);
    checkWrites(w0, 2, 32'hA00, 32'h40, 1 << 20, 0, 0, "R9 first descriptor");
    checkWrites(w0 + 2, 3, 32'hB00, 32'h80, 1 << 20, 0, 0, "R9 second descriptor");
    chk(done && intDone, "R9 list end done", {done, intDone}, 2'b11);

    // Next-descriptor at fetch: R11
    clearCfg();
    tSrc[descIdx % 16] = 32'h40; tDst[descIdx % 16] = 32'hD00; tTot[descIdx % 16] = 3; tEol[descIdx % 16] = 1;
    hwMode = 1; hwReq = 1; descMode = 1; ndIn = 1; ineDone = 1; chMaskA = 1;
    w0 = wrCnt;
    pulseStart();
    waitIdle(100);
    chk(wrCnt == w0, "R11 skipped at fetch", wrCnt - w0, 0);
    chk(done && !intDone && !irq, "R11 no done interrupt", {done, intDone, irq}, 3'b100);

    // Next-descriptor after a word: R11
    clearCfg();
    tSrc[descIdx % 16] = 32'h40; tDst[descIdx % 16] = 32'hD40; tTot[descIdx % 16] = 4; tEol[descIdx % 16] = 1;
    hwMode = 1; hwReq = 1; descMode = 1; ineDone = 1; chMaskA = 1;
    w0 = wrCnt;
    pulseStart();
    for (int i = 0; i < 100; i++) begin
      if (wrCnt != w0) break;
      @(negedge clk);
    end
    ndIn = 1;
    waitIdle(100);
    chk(wrCnt - w0 == 2, "R11 abort after word", wrCnt - w0, 2);
    chk(done && !intDone, "R11 abort without interrupt", {done, intDone}, 2'b10);

    // Auto-restart: R10
    clearCfg();
    autoRestart = 1; cfgSrc = 32'h40; cfgDst = 32'hE00; cfgTotal = 2; ineDone = 1; chMaskA = 1;
    w0 = wrCnt;
    pulseStart();
    for (int i = 0; i < 200; i++) begin
      if (wrCnt - w0 >= 6) break;
      @(negedge clk);
    end
    chk(!done && !intDone && busy, "R10 no done while restarting", {done, intDone, busy}, 3'b001);
    for (int k = 0; k < 6; k++) begin
      logic [AW-1:0] ea;
      ea = 32'hE00 + AW'(4 * (k % 2));
      chk(logAddr[(w0 + k) % 64] == ea, "R10 restart address", logAddr[(w0 + k) % 64], ea);
      chk(logData[(w0 + k) % 64] == (32'hC0DE_0000 ^ (32'h40 + AW'(4 * (k % 2)))), "R10 restart data",
          logData[(w0 + k) % 64], 32'hC0DE_0000 ^ (32'h40 + AW'(4 * (k % 2))));
    end
    stopIn = 1;
    @(negedge clk) stopIn = 0;
    chk(err && !chEn, "R10 stop ends restart loop", {err, chEn}, 2'b10);

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule